// File: doc/BRIEF.md
# Ultra DMA Data-In Burst Opener (Host Side)

This block is the host-side sequencer that opens an Ultra DMA data-in burst, holds it open, and closes it by releasing the acknowledge. While idle it passes the host's register-access chip selects and address lines straight through and drives the data bus. When the device raises its DMA request, the block first drives the burst setup. It asserts the stop line, holds the ready line negated, and forces the chip selects and address lines to their inactive levels. It waits a programmable setup time before it asserts the acknowledge. The data bus output enable drops together with the acknowledge.

After a programmable envelope time the block signals readiness: stop low and ready asserted. It then freezes both lines until the first transition of the device strobe. The strobe passes through a synchronizer and an edge detector. Each detected strobe transition is passed on as a one-cycle pulse to the data receive logic, and after the first one the block reports the burst as streaming. A burst-end request, honoured only while streaming, negates the acknowledge. The chip selects and address lines are held inactive for one further cycle, and then the block returns to idle.

All intervals are parameters in clock cycles: `T_ACK` (setup to acknowledge) and `T_ENV` (acknowledge to ready). `SYNC_STAGES` sets the synchronizer depth.

Top module: `udma_init_host`

## Requirements
- R1: After reset and while idle: dmack_n=1, stop=0, hdmardy_n=1, dd_oe=1, rx_active=0, rx_strobe=0. cs_n follows host_cs_n and da follows host_da combinationally.
- R2: When dmarq is high at a rising edge while idle, all setup levels appear together after that edge: stop=1, hdmardy_n=1, cs_n=2'b11 (bit 0 is chip select 0) and da=3'b000. dmack_n remains 1.
- R3: dmack_n falls exactly T_ACK cycles after the setup levels appear. The setup levels are held unchanged throughout that window.
- R4: dd_oe falls in the same cycle that dmack_n falls and stays 0 while dmack_n is 0.
- R5: Exactly T_ENV cycles after dmack_n falls, stop goes to 0 and hdmardy_n goes to 0, both in the same cycle.
- R6: After R5, stop and hdmardy_n do not change until the first detected dstrobe transition. rx_active rises after the third rising clock edge following a dstrobe change, with SYNC_STAGES=2.
- R7: dmack_n stays 0 from its fall until burst_end is sampled high while rx_active=1. A burst_end before the first strobe transition is ignored.
- R8: After burst_end is accepted, dmack_n=1 on the next cycle while cs_n stays 2'b11 and da stays 3'b000. One cycle later the idle levels of R1 return.
- R9: rx_strobe pulses for one cycle after the second rising edge following each dstrobe change, for rising and falling strobe edges alike. This happens only while the acknowledge is asserted and the ready level is set. dstrobe activity in idle gives no pulse and no state change.
- R10: If dmarq is still high when the block returns to idle, a new setup (R2) begins one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dmarq | input | 1 | Device DMA request |
| dstrobe | input | 1 | Device data strobe (asynchronous) |
| burst_end | input | 1 | Request to close the burst |
| host_cs_n | input | 2 | Register-access chip selects used while idle |
| host_da | input | 3 | Register-access address used while idle |
| dmack_n | output | 1 | DMA acknowledge, active low |
| stop | output | 1 | Stop line to the device |
| hdmardy_n | output | 1 | Host ready line, active low |
| cs_n | output | 2 | Chip selects to the device, active low |
| da | output | 3 | Address lines to the device |
| dd_oe | output | 1 | Host data bus output enable |
| rx_active | output | 1 | Burst streaming, receive logic in control |
| rx_strobe | output | 1 | One-cycle pulse per detected strobe transition |

## Verification
A sequencer stuck in the wrong state shows at the pins within one cycle. The levels decoded from the state would no longer match any legal combination: for example, the acknowledge low with the bus still enabled, or the address lines released while the acknowledge is low. A timer miscount shows as an acknowledge or ready change one cycle early or late, so every interval is checked cycle by cycle against the parameters. A wrong synchronizer depth or a missed edge shows as an rx_strobe pulse that is late, absent, or present during idle, and as rx_active rising on the wrong edge.

// File: rtl/udma_pkg.sv
// Package: shared state type and pin-level decode for the burst opener.
// Assumes: each state fixes one set of interface levels, independent of inputs.
package udma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_ACK     = 3'd2,
        ST_READY   = 3'd3,
        ST_STREAM  = 3'd4,
        ST_RELEASE = 3'd5
    } bstate_t;

    typedef struct packed {
        logic ack_n;
        logic stop;
        logic rdy_n;
        logic host_own;
        logic bus_oe;
        logic active;
    } pins_t;

    // Maps a state onto the interface levels it drives.
    function automatic pins_t decode_pins(bstate_t s);
        pins_t p;
        case (s)
            ST_IDLE:    p = '{ack_n:1'b1, stop:1'b0, rdy_n:1'b1, host_own:1'b1, bus_oe:1'b1, active:1'b0};
            ST_SETUP:   p = '{ack_n:1'b1, stop:1'b1, rdy_n:1'b1, host_own:1'b0, bus_oe:1'b1, active:1'b0};
            ST_ACK:     p = '{ack_n:1'b0, stop:1'b1, rdy_n:1'b1, host_own:1'b0, bus_oe:1'b0, active:1'b0};
            ST_READY:   p = '{ack_n:1'b0, stop:1'b0, rdy_n:1'b0, host_own:1'b0, bus_oe:1'b0, active:1'b0};
            ST_STREAM:  p = '{ack_n:1'b0, stop:1'b0, rdy_n:1'b0, host_own:1'b0, bus_oe:1'b0, active:1'b1};
            ST_RELEASE: p = '{ack_n:1'b1, stop:1'b0, rdy_n:1'b1, host_own:1'b0, bus_oe:1'b0, active:1'b0};
            default:    p = '{ack_n:1'b1, stop:1'b0, rdy_n:1'b1, host_own:1'b1, bus_oe:1'b1, active:1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/udma_sync.sv
// Module: multi-stage synchronizer with a both-edge detector on its output.
// Assumes: the input is asynchronous; edge is a combinational pulse one cycle wide.
module udma_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_seen
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shifts the input through one synchronizer flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else if (g == 0) chain[g] <= din;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // Remembers the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign edge_seen = chain[STAGES-1] ^ last_q;

endmodule

// File: rtl/udma_timer.sv
// Module: loadable down-counter that flags when it has reached zero.
// Assumes: the load takes priority; the count holds at zero once reached.
module udma_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Loads or decrements the interval count.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/udma_seq.sv
// Module: burst sequencer; steps through setup, acknowledge, ready and streaming.
// Assumes: dmarq and burst_end are synchronous to clk; strobe_edge comes from the synchronizer.
module udma_seq
    import udma_pkg::*;
#(
    parameter int T_ACK = 4,
    parameter int T_ENV = 3,
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dmarq,
    input  logic burst_end,
    input  logic strobe_edge,
    input  logic tmr_done,
    output logic tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output pins_t pins,
    output logic strobe_window
);
    localparam logic [CNT_W-1:0] ACK_LOAD = CNT_W'(T_ACK - 1);
    localparam logic [CNT_W-1:0] ENV_LOAD = CNT_W'(T_ENV - 1);

    bstate_t state_q, state_d;

    // Chooses the next state and the timer load for that transition.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = ACK_LOAD;
        case (state_q)
            ST_IDLE:    if (dmarq) begin
                            state_d  = ST_SETUP;
                            tmr_load = 1'b1;
                            tmr_val  = ACK_LOAD;
                        end
            ST_SETUP:   if (tmr_done) begin
                            state_d  = ST_ACK;
                            tmr_load = 1'b1;
                            tmr_val  = ENV_LOAD;
                        end
            ST_ACK:     if (tmr_done)    state_d = ST_READY;
            ST_READY:   if (strobe_edge) state_d = ST_STREAM;
            ST_STREAM:  if (burst_end)   state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Holds the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registers the interface levels decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) pins <= decode_pins(ST_IDLE);
        else        pins <= decode_pins(state_d);
    end

    assign strobe_window = (state_q == ST_READY) || (state_q == ST_STREAM);

endmodule

// File: rtl/udma_init_host.sv
// Module: top of the Ultra DMA data-in burst opener on the host side.
// Assumes: T_ACK >= 1 and T_ENV >= 1; host register lines are stable while idle.
module udma_init_host
    import udma_pkg::*;
#(
    parameter int T_ACK       = 4,
    parameter int T_ENV       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int CS_W        = 2,
    parameter int DA_W        = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dmarq,
    input  logic            dstrobe,
    input  logic            burst_end,
    input  logic [CS_W-1:0] host_cs_n,
    input  logic [DA_W-1:0] host_da,
    output logic            dmack_n,
    output logic            stop,
    output logic            hdmardy_n,
    output logic [CS_W-1:0] cs_n,
    output logic [DA_W-1:0] da,
    output logic            dd_oe,
    output logic            rx_active,
    output logic            rx_strobe
);
    localparam int T_MAX = (T_ACK > T_ENV) ? T_ACK : T_ENV;
    localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;

    logic             strobe_edge;
    logic             tmr_load;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             strobe_window;
    pins_t            pins;

    udma_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (dstrobe),
        .edge_seen (strobe_edge)
    );

    udma_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    udma_seq #(.T_ACK(T_ACK), .T_ENV(T_ENV), .CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .dmarq         (dmarq),
        .burst_end     (burst_end),
        .strobe_edge   (strobe_edge),
        .tmr_done      (tmr_done),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .pins          (pins),
        .strobe_window (strobe_window)
    );

    assign dmack_n   = pins.ack_n;
    assign stop      = pins.stop;
    assign hdmardy_n = pins.rdy_n;
    assign dd_oe     = pins.bus_oe;
    assign rx_active = pins.active;
    assign cs_n      = pins.host_own ? host_cs_n : {CS_W{1'b1}};
    assign da        = pins.host_own ? host_da   : {DA_W{1'b0}};
    assign rx_strobe = strobe_edge && strobe_window;

endmodule

// File: rtl/udma_init_host_chk.sv
// Module: protocol checker for the burst opener, bound to every instance of the top.
// Assumes: observes ports only; reset is synchronous active-low.
module udma_init_host_chk #(
    parameter int CS_W = 2,
    parameter int DA_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dmarq,
    input logic            burst_end,
    input logic            dmack_n,
    input logic            stop,
    input logic            hdmardy_n,
    input logic [CS_W-1:0] cs_n,
    input logic [DA_W-1:0] da,
    input logic            dd_oe,
    input logic            rx_active,
    input logic            rx_strobe
);
    // R2: setup begins only on a device request, with all lines already inactive.
    p_setup_on_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop) |-> $past(dmarq) && hdmardy_n && dmack_n && (cs_n == {CS_W{1'b1}}) && (da == '0));

    // R3: the acknowledge falls only out of a held setup.
    p_ack_after_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dmack_n) |-> $past(stop) && $past(hdmardy_n) && stop && hdmardy_n);

    // R4: the host never drives the bus while the acknowledge is asserted.
    p_bus_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dmack_n |-> !dd_oe);

    // R6: once ready is signalled, stop and ready stay put until streaming starts.
    p_ready_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dmack_n && $past(!dmack_n) && $past(!stop) && !rx_active) |-> (!stop && !hdmardy_n));

    // R7: the acknowledge is released only after an accepted burst-end.
    p_ack_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!dmack_n) && !$past(burst_end && rx_active)) |-> !dmack_n);

    // R8: chip selects and address stay inactive during and just after the burst.
    p_lines_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dmack_n || $past(!dmack_n)) |-> ((cs_n == {CS_W{1'b1}}) && (da == '0)));

    // R9: no strobe pulse reaches the receive logic outside the burst.
    p_no_idle_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dmack_n |-> !rx_strobe);

endmodule

bind udma_init_host udma_init_host_chk #(.CS_W(CS_W), .DA_W(DA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dmarq     (dmarq),
    .burst_end (burst_end),
    .dmack_n   (dmack_n),
    .stop      (stop),
    .hdmardy_n (hdmardy_n),
    .cs_n      (cs_n),
    .da        (da),
    .dd_oe     (dd_oe),
    .rx_active (rx_active),
    .rx_strobe (rx_strobe)
);

// File: tb/udma_init_host_bench.sv
// Bench: directed scenarios for the burst opener; inputs change and outputs are sampled at the falling edge.
module udma_init_host_bench;
    localparam int T_ACK = 4;
    localparam int T_ENV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dmarq = 1'b0;
    logic       dstrobe = 1'b0;
    logic       burst_end = 1'b0;
    logic [1:0] host_cs_n = 2'b10;
    logic [2:0] host_da = 3'b101;
    logic       dmack_n, stop, hdmardy_n, dd_oe, rx_active, rx_strobe;
    logic [1:0] cs_n;
    logic [2:0] da;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    udma_init_host #(.T_ACK(T_ACK), .T_ENV(T_ENV), .SYNC_STAGES(2)) u_udma_init_host (
        .clk(clk), .rst_n(rst_n), .dmarq(dmarq), .dstrobe(dstrobe), .burst_end(burst_end),
        .host_cs_n(host_cs_n), .host_da(host_da), .dmack_n(dmack_n), .stop(stop),
        .hdmardy_n(hdmardy_n), .cs_n(cs_n), .da(da), .dd_oe(dd_oe),
        .rx_active(rx_active), .rx_strobe(rx_strobe)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Checks the full idle level set against the current host lines.
    task automatic chk_idle(input string tag);
        chk({tag, " dmack_n"}, dmack_n, 1);
        chk({tag, " stop"}, stop, 0);
        chk({tag, " hdmardy_n"}, hdmardy_n, 1);
        chk({tag, " dd_oe"}, dd_oe, 1);
        chk({tag, " rx_active"}, rx_active, 0);
        chk({tag, " cs_n"}, cs_n, host_cs_n);
        chk({tag, " da"}, da, host_da);
    endtask

    // Opens a burst from idle with dmarq and checks setup, acknowledge and ready timing.
    task automatic open_burst();
        dmarq = 1'b1;
        step();
        chk("R2 stop", stop, 1);
        chk("R2 hdmardy_n", hdmardy_n, 1);
        chk("R2 cs_n", cs_n, 3);
        chk("R2 da", da, 0);
        chk("R2 dmack_n", dmack_n, 1);
        for (int k = 1; k <= T_ACK; k++) begin
            step();
            chk($sformatf("R3 dmack_n at %0d", k), dmack_n, (k < T_ACK) ? 1 : 0);
            if (k < T_ACK) chk("R3 stop held", stop, 1);
        end
        chk("R4 dd_oe", dd_oe, 0);
        for (int k = 1; k <= T_ENV; k++) begin
            step();
            chk($sformatf("R5 stop at %0d", k), stop, (k < T_ENV) ? 1 : 0);
            chk($sformatf("R5 hdmardy_n at %0d", k), hdmardy_n, (k < T_ENV) ? 1 : 0);
        end
    endtask

    // Toggles dstrobe and checks the pulse on the second edge and streaming on the third.
    task automatic strobe_edge(input bit first);
        dstrobe = ~dstrobe;
        step();
        chk("R9 no pulse yet", rx_strobe, 0);
        step();
        chk("R9 pulse", rx_strobe, 1);
        if (first) chk("R6 not yet active", rx_active, 0);
        step();
        chk("R9 pulse one cycle", rx_strobe, 0);
        chk("R6 active", rx_active, 1);
    endtask

    // Closes the burst and checks the release cycle.
    task automatic close_burst();
        burst_end = 1'b1;
        step();
        burst_end = 1'b0;
        chk("R8 dmack_n released", dmack_n, 1);
        chk("R8 cs_n held", cs_n, 3);
        chk("R8 da held", da, 0);
    endtask

    task automatic t_reset();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk_idle("R1 reset");
        chk("R1 rx_strobe", rx_strobe, 0);
        host_cs_n = 2'b01;
        host_da = 3'b011;
        #1;
        chk("R1 cs_n follows", cs_n, 1);
        chk("R1 da follows", da, 3);
    endtask

    task automatic t_idle_strobe();
        for (int n = 0; n < 3; n++) begin
            dstrobe = ~dstrobe;
            step();
            chk("R9 idle no pulse", rx_strobe, 0);
            step();
            chk("R9 idle no pulse", rx_strobe, 0);
            chk("R9 idle dmack_n", dmack_n, 1);
        end
        repeat (2) step();
        chk_idle("R9 idle after strobes");
    endtask

    task automatic t_full_burst();
        open_burst();
        burst_end = 1'b1;
        repeat (2) begin
            step();
            chk("R7 early end ignored", dmack_n, 0);
            chk("R6 stop frozen", stop, 0);
            chk("R6 hdmardy_n frozen", hdmardy_n, 0);
        end
        burst_end = 1'b0;
        repeat (2) step();
        chk("R6 still frozen", hdmardy_n, 0);
        strobe_edge(1'b1);
        dmarq = 1'b0;
        strobe_edge(1'b0);
        repeat (3) begin
            step();
            chk("R7 held while streaming", dmack_n, 0);
        end
        close_burst();
        host_cs_n = 2'b00;
        host_da = 3'b110;
        step();
        chk_idle("R8 idle returns");
    endtask

    task automatic t_back_to_back();
        open_burst();
        strobe_edge(1'b1);
        close_burst();
        step();
        chk("R10 idle cycle", stop, 0);
        chk("R10 idle cs_n", cs_n, host_cs_n);
        step();
        chk("R10 new setup", stop, 1);
        chk("R10 new setup cs_n", cs_n, 3);
        dmarq = 1'b0;
        for (int k = 1; k <= T_ACK; k++) step();
        chk("R10 second ack", dmack_n, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_strobe();
        t_full_burst();
        t_back_to_back();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule